// File: doc/BRIEF.md
# Interleaved Memory Line Refill Controller

This block answers cache-line refill requests from a main memory built as several one-word-wide banks with word interleaving. A word address selects its bank by the remainder after division by the bank count. The quotient selects the row inside that bank. A line holds one word from each bank, so a request for line `L` reads row `L` in every bank. The bank storage is modelled inside the block as plain arrays, and a single-word write port fills those arrays.

After it accepts a request, the block spends a fixed number of cycles sending the address to all banks at once. It then waits out the access time, during which every bank reads in parallel. The captured words then leave through the return stream. In shared-bus mode the words leave one per transfer slot, in ascending bank order. In independent-bus mode every bank has its own path, so the whole line leaves in a single beat after one transfer slot. With the default timing (4 address cycles, 24 access cycles, 4 cycles per word) a line takes 44 cycles on the shared bus and 32 cycles with independent buses.

Top module: `ilv_line_fetch`

## Requirements
- R1: A word written at word address `A` (through `wr_en`/`wr_addr`/`wr_data`) is stored in bank `A mod 4` at row `A div 4`. A later read of line `L` returns the word at address `4*L+k` in lane `k`.
- R2: After reset `req_ready` is 1 and `rsp_valid` is 0.
- R3: In shared mode (`req_indep`=0 at acceptance), each beat carries exactly one word. Word `k` of the line is returned with `rsp_mask` equal to `1<<k` and `rsp_idx`=`k`. Its data is in lane `k`, which is bits `[32*k +: 32]` of `rsp_data`, and every other lane reads zero.
- R4: In shared mode the words come out in the order 0, 1, 2, 3. `rsp_last` is 1 only on the word 3 beat.
- R5: In independent mode (`req_indep`=1 at acceptance), the line is returned in one beat with `rsp_mask`=4'b1111, `rsp_idx`=0 and `rsp_last`=1.
- R6: Timing counts cycles from the acceptance edge, where cycle 1 follows that edge. In shared mode word `k` is valid in cycle 4+24+4*(k+1), so the last word arrives in cycle 44. In independent mode the beat is valid in cycle 32. `req_ready` returns in the cycle after the final beat.
- R7: While a line is in progress, `req_ready` is 0 and a held `req_valid` is not accepted. The waiting request is taken only once `req_ready` has returned.
- R8: The mode and line address are sampled at acceptance. Changing `req_indep` or `req_line` while a line is in progress does not change that line's beats.
- R9: `rsp_valid` is never 1 outside the beats listed in R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_line | input | LINE_W | Line index (row in every bank) |
| req_indep | input | 1 | 1 = independent bank buses, 0 = shared bus |
| wr_en | input | 1 | Write one word into the bank arrays |
| wr_addr | input | LINE_W+2 | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | Return beat present |
| rsp_mask | output | NUM_BANKS | Lanes carrying a word in this beat |
| rsp_idx | output | 2 | Index of the lowest word in this beat |
| rsp_data | output | NUM_BANKS*DATA_W | Lane k holds word k |
| rsp_last | output | 1 | Final beat of the line |

## Verification
The hardest case to reach from the ports is a new request that is held valid through an entire line. A correct design must ignore it until the cycle after the last beat and then accept it on the first idle edge. The stimulus issues each next request immediately after the previous acceptance, in both modes. The acceptance-cycle spacing (45 shared, 33 independent) and the absence of stray beats show that the hand-off is exact. In the same way, flipping the mode input in the middle of a shared-bus line tests that the mode was latched at acceptance.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ADDR   = 2'd1,
    PH_ACCESS = 2'd2,
    PH_XFER   = 2'd3
  } phase_e;

  // Bank that owns a word address.
  function automatic int bank_of(input int word_addr, input int nbanks);
    return word_addr % nbanks;
  endfunction

  // Row inside the owning bank.
  function automatic int row_of(input int word_addr, input int nbanks);
    return word_addr / nbanks;
  endfunction

  // Cycle (counted from acceptance) in which word k is presented.
  function automatic int beat_cycle(input int k, input bit indep,
                                    input int a_cyc, input int m_cyc,
                                    input int x_cyc);
    if (indep) return a_cyc + m_cyc + x_cyc;
    return a_cyc + m_cyc + (k + 1) * x_cyc;
  endfunction

endpackage

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 24,
  parameter int XFER_CYC  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_indep,
  output logic                         req_ready,
  output logic                         accept,
  output logic                         capture,
  output logic                         beat,
  output logic                         beat_last,
  output logic [$clog2(NUM_BANKS)-1:0] word_idx,
  output logic                         indep_q,
  output logic                         busy
);
  localparam int IDX_W  = $clog2(NUM_BANKS);
  localparam int MAX_AM = (ADDR_CYC > ACC_CYC) ? ADDR_CYC : ACC_CYC;
  localparam int MAX_C  = (MAX_AM > XFER_CYC) ? MAX_AM : XFER_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_BANKS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] word_q, word_d;
  logic             indep_d;

  assign req_ready = (phase_q == PH_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;
  assign capture   = (phase_q == PH_ACCESS) && (cnt_q == '0);
  assign beat      = (phase_q == PH_XFER) && (cnt_q == '0);
  assign beat_last = beat && (indep_q || (word_q == LAST_WORD));
  assign word_idx  = word_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    indep_d = indep_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_ADDR;
          cnt_d   = CNT_W'(ADDR_CYC - 1);
          word_d  = '0;
          indep_d = req_indep;
        end
      end
      PH_ADDR: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACCESS;
          cnt_d   = CNT_W'(ACC_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACCESS: begin
        if (cnt_q == '0) begin
          phase_d = PH_XFER;
          cnt_d   = CNT_W'(XFER_CYC - 1);
          word_d  = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_XFER: begin
        if (cnt_q == '0) begin
          if (beat_last) begin
            phase_d = PH_IDLE;
          end else begin
            word_d = word_q + 1'b1;
            cnt_d  = CNT_W'(XFER_CYC - 1);
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
      indep_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      word_q  <= word_d;
      indep_q <= indep_d;
    end
  end

  AST_ACCEPT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase_q == PH_ADDR) && !req_ready); // R7
  AST_CAPTURE_THEN_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (phase_q == PH_XFER) && (word_q == '0)); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(indep_q)); // R8
  AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> req_ready); // R6

endmodule

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_pkg::*;
#(
  parameter int BANK_ID   = 0,
  parameter int NUM_BANKS = 4,
  parameter int LINE_W    = 5,
  parameter int DATA_W    = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [LINE_W+$clog2(NUM_BANKS)-1:0]  wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic [LINE_W-1:0]                    rd_row,
  input  logic                                 capture,
  output logic [DATA_W-1:0]                    data_q
);
  localparam int ROWS = 1 << LINE_W;

  logic [DATA_W-1:0] mem [ROWS];
  logic              wr_hit;
  logic [LINE_W-1:0] wr_row;

  assign wr_hit = wr_en && (bank_of(int'(wr_addr), NUM_BANKS) == BANK_ID);
  assign wr_row = LINE_W'(row_of(int'(wr_addr), NUM_BANKS));

  always_ff @(posedge clk) begin
    if (wr_hit) mem[wr_row] <= wr_data;
  end

  // Word leaves the bank at the end of the access window.
  always_ff @(posedge clk) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= mem[rd_row];
  end

endmodule

// File: rtl/ilv_rsp.sv
module ilv_rsp #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32
) (
  input  logic                         beat,
  input  logic                         beat_last,
  input  logic                         indep_q,
  input  logic [$clog2(NUM_BANKS)-1:0] word_idx,
  input  logic [NUM_BANKS*DATA_W-1:0]  lane_data,
  output logic                         rsp_valid,
  output logic [NUM_BANKS-1:0]         rsp_mask,
  output logic [$clog2(NUM_BANKS)-1:0] rsp_idx,
  output logic [NUM_BANKS*DATA_W-1:0]  rsp_data,
  output logic                         rsp_last
);
  localparam int IDX_W = $clog2(NUM_BANKS);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_lane
    assign rsp_mask[k] = beat && (indep_q || (word_idx == IDX_W'(k)));
    assign rsp_data[k*DATA_W +: DATA_W] =
      rsp_mask[k] ? lane_data[k*DATA_W +: DATA_W] : '0;
  end

  assign rsp_valid = beat;
  assign rsp_idx   = indep_q ? '0 : word_idx;
  assign rsp_last  = beat_last;

endmodule

// File: rtl/ilv_line_fetch.sv
module ilv_line_fetch
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int LINE_W    = 5,
  parameter int DATA_W    = 32,
  parameter int ADDR_CYC  = 4,
  parameter int ACC_CYC   = 24,
  parameter int XFER_CYC  = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [LINE_W-1:0]                   req_line,
  input  logic                                req_indep,
  input  logic                                wr_en,
  input  logic [LINE_W+$clog2(NUM_BANKS)-1:0] wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic                                rsp_valid,
  output logic [NUM_BANKS-1:0]                rsp_mask,
  output logic [$clog2(NUM_BANKS)-1:0]        rsp_idx,
  output logic [NUM_BANKS*DATA_W-1:0]         rsp_data,
  output logic                                rsp_last
);
  localparam int IDX_W     = $clog2(NUM_BANKS);
  localparam int T_FIRST   = beat_cycle(0, 1'b0, ADDR_CYC, ACC_CYC, XFER_CYC);
  localparam int T_LAST_SH = beat_cycle(NUM_BANKS - 1, 1'b0, ADDR_CYC, ACC_CYC, XFER_CYC);
  localparam int LAT_W     = $clog2(T_LAST_SH + 2);

  logic                        accept, capture, beat, beat_last, indep_q, busy;
  logic [IDX_W-1:0]            word_idx;
  logic [LINE_W-1:0]           line_q;
  logic [NUM_BANKS*DATA_W-1:0] lane_data;
  logic [LAT_W-1:0]            lat_cnt;

  ilv_seq #(
    .NUM_BANKS(NUM_BANKS), .ADDR_CYC(ADDR_CYC),
    .ACC_CYC(ACC_CYC), .XFER_CYC(XFER_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_indep(req_indep),
    .req_ready(req_ready), .accept(accept), .capture(capture), .beat(beat),
    .beat_last(beat_last), .word_idx(word_idx), .indep_q(indep_q), .busy(busy)
  );

  // Line address is broadcast to every bank once, at acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n)      line_q <= '0;
    else if (accept) line_q <= req_line;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(
      .BANK_ID(b), .NUM_BANKS(NUM_BANKS), .LINE_W(LINE_W), .DATA_W(DATA_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_row(line_q), .capture(capture),
      .data_q(lane_data[b*DATA_W +: DATA_W])
    );
  end

  ilv_rsp #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_rsp (
    .beat(beat), .beat_last(beat_last), .indep_q(indep_q), .word_idx(word_idx),
    .lane_data(lane_data), .rsp_valid(rsp_valid), .rsp_mask(rsp_mask),
    .rsp_idx(rsp_idx), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  // Cycles since acceptance, kept only to time-check the beats.
  always_ff @(posedge clk) begin
    if (!rst_n)      lat_cnt <= '0;
    else if (accept) lat_cnt <= LAT_W'(1);
    else if (busy)   lat_cnt <= lat_cnt + 1'b1;
    else             lat_cnt <= '0;
  end

  AST_SHARED_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !indep_q) |-> ($countones(rsp_mask) == 1)); // R3
  AST_INDEP_WHOLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && indep_q) |-> ((&rsp_mask) && rsp_last)); // R5
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid); // R4
  AST_FIRST_BEAT_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_idx == '0)) |-> (lat_cnt == LAT_W'(T_FIRST))); // R6
  AST_LAST_BEAT_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_last && !indep_q) |-> (lat_cnt == LAT_W'(T_LAST_SH))); // R6
  AST_NO_IDLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid); // R9

endmodule

// File: tb/tb_ilv_line_fetch.sv
`timescale 1ns/1ps
module tb_ilv_line_fetch;
  localparam int NB  = 4;
  localparam int DW  = 32;
  localparam int LW  = 5;
  localparam int WAW = LW + 2;
  localparam int NW  = NB * (1 << LW);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_indep = 1'b0;
  logic [LW-1:0]     req_line = '0;
  logic              wr_en = 1'b0;
  logic [WAW-1:0]    wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic              req_ready, rsp_valid, rsp_last;
  logic [NB-1:0]     rsp_mask;
  logic [1:0]        rsp_idx;
  logic [NB*DW-1:0]  rsp_data;

  ilv_line_fetch dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_line(req_line), .req_indep(req_indep), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rsp_valid(rsp_valid),
    .rsp_mask(rsp_mask), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
    .rsp_last(rsp_last)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int               at;
    logic [NB-1:0]    mask;
    int               idx;
    logic             last;
    logic [NB*DW-1:0] data;
    string            tag;
  } beat_t;

  beat_t       exp_q[$];
  logic [DW-1:0] model [NW];
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [NB*DW-1:0] act,
                     input logic [NB*DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = WAW'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // Issue a line request; returns the cycle count seen just before the accepting edge.
  task automatic send_line(input int line, input bit indep, input string tag,
                           output int acc);
    beat_t b;
    @(negedge clk);
    req_valid = 1'b1; req_line = LW'(line); req_indep = indep;
    while (!req_ready) @(negedge clk);
    acc = cyc;
    if (indep) begin
      b.at = acc + 4 + 24 + 4; b.mask = '1; b.idx = 0; b.last = 1'b1;
      for (int k = 0; k < NB; k++) b.data[k*DW +: DW] = model[line*NB + k];
      b.tag = {tag, " R5"};
      exp_q.push_back(b);
    end else begin
      for (int k = 0; k < NB; k++) begin
        b.at = acc + 4 + 24 + 4 * (k + 1);
        b.mask = NB'(1) << k; b.idx = k; b.last = (k == NB - 1);
        b.data = '0;
        b.data[k*DW +: DW] = model[line*NB + k];
        b.tag = {tag, " R3 R4"};
        exp_q.push_back(b);
      end
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected beat", NB*DW'(cyc), '0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(cyc == e.at, {e.tag, " R6 beat cycle"}, NB*DW'(cyc), NB*DW'(e.at));
        chk(rsp_mask == e.mask, {e.tag, " mask"}, NB*DW'(rsp_mask), NB*DW'(e.mask));
        chk(int'(rsp_idx) == e.idx, {e.tag, " idx"}, NB*DW'(rsp_idx), NB*DW'(e.idx));
        chk(rsp_last == e.last, {e.tag, " last"}, NB*DW'(rsp_last), NB*DW'(e.last));
        chk(rsp_data == e.data, {e.tag, " R1 data"}, rsp_data, e.data);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int a0, a1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready after reset", NB*DW'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R2 no beat after reset", NB*DW'(rsp_valid), 0);

    // R1: fill every word by word address
    for (int a = 0; a < NW; a++) begin
      model[a] = 32'h3C00_0000 ^ (DW'(a) * 32'h0001_0101);
      write_word(a, model[a]);
    end
    model[22] = 32'hDEAD_BEEF;   // line 5, bank 2
    write_word(22, model[22]);

    send_line(5, 1'b0, "line5 shared", a0);
    drain();
    chk(req_ready == 1'b1, "R6 ready after line", NB*DW'(req_ready), 1);

    send_line(0, 1'b1, "line0 indep", a0);
    drain();

    // R7: next request held valid while the first is in progress
    send_line(31, 1'b0, "line31 shared", a0);
    send_line(31, 1'b1, "line31 indep", a1);
    chk(a1 - a0 == 45, "R7 R6 hand-off after shared line", NB*DW'(a1 - a0), 45);
    drain();

    send_line(9, 1'b1, "line9 indep", a0);
    send_line(10, 1'b0, "line10 shared", a1);
    chk(a1 - a0 == 33, "R7 R6 hand-off after indep line", NB*DW'(a1 - a0), 33);
    drain();

    // R8: mode and line inputs change mid-line
    send_line(12, 1'b0, "line12 shared R8", a0);
    repeat (10) @(negedge clk);
    req_indep = 1'b1; req_line = LW'(3);
    drain();

    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all beats seen", NB*DW'(exp_q.size()), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule